// File: doc/BRIEF.md
# Dynamic Voltage Scaling Setpoint Ramp

This block produces the 7-bit voltage code that a switching regulator's control loop uses as its reference. Two preset codes come in from configuration storage: a low-select preset and a high-select preset. A voltage-select pin chooses between them. Once soft start has finished, the block does not let a new target reach the loop in one jump. It moves the setpoint one code (25 mV) at a time. The interval between steps follows a 2-bit slew code, counted in ticks of a 0.5 µs timebase.

A new target is taken in two cases. The first is when the select pin settles at a new level. The second is when configuration logic pulses a write strobe after changing the active preset. Before soft start completes, the setpoint follows the target at once. A ramp-busy output is high while stepping is in progress, so that the mode logic can hold the converter in forced-PWM during the ramp. If the target changes in the middle of a ramp, the ramp continues from the present code in whichever direction is now needed.

Top module: `dvs_ramp_ctrl`

## Requirements
- R1: During and just after reset, `vset_o` equals the preset selected by the level of `vsel_i` (low selects `vout_lo_i`, high selects `vout_hi_i`), and `ramp_busy_o` is low.
- R2: While `ss_done_i` is low, `vset_o` takes a newly latched target two clock cycles after the write strobe, and `ramp_busy_o` stays low.
- R3: After soft start, a write strobe that latches a target different from `vset_o` starts a ramp in which every change of `vset_o` is exactly one code.
- R4: Slew codes 00, 01, 10 and 11 give step intervals of 50, 20, 10 and 5 ticks. The first step lands on the Nth tick after the ramp begins, and each later step lands N ticks after the one before it.
- R5: Steps move toward the target, both upward and downward, and stepping stops when `vset_o` equals the target.
- R6: A new `vsel_i` level is acted on once it has been held across 10 consecutive ticks. The ramp then heads to the preset for that level.
- R7: A `vsel_i` excursion that ends before its 10th tick changes neither `vset_o` nor `ramp_busy_o`.
- R8: A new target latched mid-ramp redirects the ramp from the present `vset_o`, reversing direction if needed. The step interval that is already running continues.
- R9: `ramp_busy_o` is high exactly when `ss_done_i` is high and `vset_o` differs from the latched target.
- R10: A slew change during a ramp applies from the next step. If the ticks already counted reach the new interval, the step occurs on the next tick.
- R11: A preset change without a write strobe, and a strobe that leaves the selected preset's value unchanged, have no effect on `vset_o` or `ramp_busy_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase pulse, every 0.5 µs |
| vsel_i | input | 1 | Preset select level, synchronous to clk |
| vout_lo_i | input | 7 | Preset code used when select is low |
| vout_hi_i | input | 7 | Preset code used when select is high |
| slew_i | input | 2 | Step interval code |
| ss_done_i | input | 1 | High once soft start has completed |
| wr_stb_i | input | 1 | One-cycle pulse when the active preset has been written |
| vset_o | output | 7 | Setpoint code sent to the regulation loop |
| ramp_busy_o | output | 1 | High while the setpoint is stepping toward the target |

## Verification
The bench counts ticks between setpoint changes for every slew code. A wrong interval table, or a counter that is off by one, moves the step early or late by one tick. Select pulses of nine ticks test the glitch filter: a filter that is one tick too short would start a ramp. Retargeting in the middle of a ramp, and shortening the slew while a step interval is partly counted, check that the design neither freezes, overshoots nor restarts the interval. Strobes that leave the selected value unchanged, and preset edits made without a strobe, catch a design that tracks the raw preset inputs directly.

// File: rtl/dvs_pkg.sv
// Shared constants and helpers for the setpoint ramp.
// Assumes a 25 mV code step; the step time per slew code follows from it.
package dvs_pkg;

    // Time between 25 mV steps for each slew code, in nanoseconds.
    function automatic int step_time_ns(input logic [1:0] code);
        case (code)
            2'b00:   return 25000;   // 1 V/ms
            2'b01:   return 10000;   // 2.5 V/ms
            2'b10:   return 5000;    // 5 V/ms
            default: return 2500;    // 10 V/ms
        endcase
    endfunction

endpackage

// File: rtl/dvs_vsel_qual.sv
// Select-pin qualifier: the qualified level takes a new raw level only
// after that level has been seen on HOLD_TICKS consecutive ticks.
// Assumes vsel_raw is already synchronous to clk.
module dvs_vsel_qual #(
    parameter int HOLD_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic vsel_raw,
    output logic vsel_q,
    output logic flip
);
    localparam int HW = $clog2(HOLD_TICKS + 1);

    logic [HW-1:0] hold_cnt;

    // Count ticks while the raw level differs; commit when the hold time is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            vsel_q   <= vsel_raw;
            flip     <= 1'b0;
        end else begin
            flip <= 1'b0;
            if (vsel_raw == vsel_q) begin
                hold_cnt <= '0;
            end else if (tick) begin
                if (hold_cnt == HW'(HOLD_TICKS - 1)) begin
                    vsel_q   <= vsel_raw;
                    flip     <= 1'b1;
                    hold_cnt <= '0;
                end else begin
                    hold_cnt <= hold_cnt + 1'b1;
                end
            end
        end
    end

    // The qualified level moves only on a tick, and only to the raw level.
    assert_qual_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (vsel_q != $past(vsel_q))) |-> ($past(tick) && ($past(vsel_raw) == vsel_q)));

endmodule

// File: rtl/dvs_target_sel.sv
// Target latch: captures the preset chosen by the qualified select level
// when the active preset is written or when the qualified level flips.
// Assumes the write strobe is one cycle and comes after the preset has settled.
module dvs_target_sel #(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsel_q,
    input  logic              flip,
    input  logic              wr_stb,
    input  logic [CODE_W-1:0] vout_lo,
    input  logic [CODE_W-1:0] vout_hi,
    input  logic [CODE_W-1:0] init_code,
    output logic [CODE_W-1:0] target
);
    logic [CODE_W-1:0] picked;

    // Preset chosen by the qualified select level.
    always_comb picked = vsel_q ? vout_hi : vout_lo;

    // Latch the target only on an explicit update event.
    always_ff @(posedge clk) begin
        if (!rst_n)              target <= init_code;
        else if (wr_stb || flip) target <= picked;
    end

    // Without a strobe or a flip the target holds.
    assert_target_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_stb) && !$past(flip)) |-> $stable(target));

endmodule

// File: rtl/dvs_step_timer.sv
// Step timer: counts timebase ticks while a ramp is busy and fires a step
// when the count reaches the interval for the current slew code.
// Assumes every interval is at least one tick.
module dvs_step_timer #(
    parameter int TICK_NS = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       busy,
    input  logic [1:0] slew,
    output logic       step
);
    localparam int MAX_TICKS = dvs_pkg::step_time_ns(2'b00) / TICK_NS;
    localparam int CW        = $clog2(MAX_TICKS + 1);

    logic [CW-1:0] lim_tab [4];
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          at_lim;

    // One interval constant per slew code.
    for (genvar g = 0; g < 4; g++) begin : g_lim
        assign lim_tab[g] = CW'(dvs_pkg::step_time_ns(2'(g)) / TICK_NS);
    end

    // Interval of the current slew code, compared each tick.
    always_comb begin
        lim    = lim_tab[slew];
        at_lim = (cnt >= lim - 1'b1);
        step   = busy && tick && at_lim;
    end

    // Tick counter, cleared when idle and after every step.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (!busy)  cnt <= '0;
        else if (tick)   cnt <= at_lim ? '0 : cnt + 1'b1;
    end

    // A step needs a tick and an active ramp.
    assert_step_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (tick && busy));

endmodule

// File: rtl/dvs_setpoint.sv
// Setpoint register: follows the target directly before soft start ends,
// then moves one code toward it on each step pulse.
// Assumes the target and step inputs are registered or derived from registers.
module dvs_setpoint #(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_done,
    input  logic              step,
    input  logic [CODE_W-1:0] target,
    input  logic [CODE_W-1:0] init_code,
    output logic [CODE_W-1:0] vset,
    output logic              busy
);
    // Ramp in progress whenever the setpoint lags the target after soft start.
    always_comb busy = ss_done && (vset != target);

    // Jump before soft start, single-code steps after it.
    always_ff @(posedge clk) begin
        if (!rst_n)                vset <= init_code;
        else if (!ss_done)         vset <= target;
        else if (step && busy)     vset <= (target > vset) ? vset + 1'b1 : vset - 1'b1;
    end

    // Before soft start the setpoint copies the target one cycle later.
    assert_jump_pre_ss_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ss_done)) |-> (vset == $past(target)));

    // After soft start the setpoint never moves by more than one code.
    assert_single_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ss_done)) |->
        ((vset == $past(vset)) || (vset == $past(vset) + 1'b1) || (vset == $past(vset) - 1'b1)));

    // After soft start the setpoint changes only on a step.
    assert_no_move_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ss_done) && !$past(step)) |-> $stable(vset));

    // A step always goes toward the target seen at that step.
    assert_toward_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ss_done) && $past(step) && ($past(vset) != $past(target))) |->
        ((vset > $past(vset)) == ($past(target) > $past(vset))));

endmodule

// File: rtl/dvs_ramp_ctrl.sv
// Dynamic voltage scaling setpoint ramp: qualifies the select pin, latches
// the target preset, and steps the setpoint toward it at the slew interval.
// Assumes all inputs are synchronous to clk and tick_i is a one-cycle pulse.
module dvs_ramp_ctrl #(
    parameter int CODE_W       = 7,
    parameter int TICK_NS      = 500,
    parameter int VSEL_HOLD_NS = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              vsel_i,
    input  logic [CODE_W-1:0] vout_lo_i,
    input  logic [CODE_W-1:0] vout_hi_i,
    input  logic [1:0]        slew_i,
    input  logic              ss_done_i,
    input  logic              wr_stb_i,
    output logic [CODE_W-1:0] vset_o,
    output logic              ramp_busy_o
);
    localparam int HOLD_TICKS = VSEL_HOLD_NS / TICK_NS;

    logic              vsel_q;
    logic              flip;
    logic              step;
    logic              busy;
    logic [CODE_W-1:0] target;
    logic [CODE_W-1:0] init_code;

    // Reset value: the preset picked by the raw select level.
    always_comb init_code = vsel_i ? vout_hi_i : vout_lo_i;

    dvs_vsel_qual #(.HOLD_TICKS(HOLD_TICKS)) u_qual (
        .clk(clk), .rst_n(rst_n), .tick(tick_i), .vsel_raw(vsel_i),
        .vsel_q(vsel_q), .flip(flip)
    );

    dvs_target_sel #(.CODE_W(CODE_W)) u_tgt (
        .clk(clk), .rst_n(rst_n), .vsel_q(vsel_q), .flip(flip), .wr_stb(wr_stb_i),
        .vout_lo(vout_lo_i), .vout_hi(vout_hi_i), .init_code(init_code), .target(target)
    );

    dvs_step_timer #(.TICK_NS(TICK_NS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick_i), .busy(busy), .slew(slew_i), .step(step)
    );

    dvs_setpoint #(.CODE_W(CODE_W)) u_sp (
        .clk(clk), .rst_n(rst_n), .ss_done(ss_done_i), .step(step),
        .target(target), .init_code(init_code), .vset(vset_o), .busy(busy)
    );

    always_comb ramp_busy_o = busy;

    // Before soft start no ramp is ever reported.
    assert_idle_pre_ss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_done_i |-> !ramp_busy_o);

endmodule

// File: tb/dvs_ramp_ctrl_test.sv
`timescale 1ns/1ps
module dvs_ramp_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       vsel_i = 1'b0;
    logic [6:0] vout_lo_i = 7'd20;
    logic [6:0] vout_hi_i = 7'd40;
    logic [1:0] slew_i = 2'b00;
    logic       ss_done_i = 1'b0;
    logic       wr_stb_i = 1'b0;
    logic [6:0] vset_o;
    logic       ramp_busy_o;

    int vectors = 0;
    int miscompares = 0;
    int cur = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dvs_ramp_ctrl uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .vsel_i(vsel_i),
        .vout_lo_i(vout_lo_i), .vout_hi_i(vout_hi_i), .slew_i(slew_i),
        .ss_done_i(ss_done_i), .wr_stb_i(wr_stb_i),
        .vset_o(vset_o), .ramp_busy_o(ramp_busy_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick1();
        tick_i = 1'b1; @(negedge clk);
        tick_i = 1'b0; @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick1();
    endtask

    task automatic strobe();
        wr_stb_i = 1'b1; @(negedge clk);
        wr_stb_i = 1'b0;
    endtask

    // n steps at interval lim in direction dir, checking each tick boundary.
    task automatic walk(input int n, input int lim, input int dir, input string tag);
        for (int s = 0; s < n; s++) begin
            ticks(lim - 1);
            check({tag, " hold before step (R4)"}, vset_o, cur);
            tick1();
            cur += dir;
            check({tag, " one-code step (R3)"}, vset_o, cur);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cyc(3); rst_n = 1'b1; cyc(1);
        cur = 20;
        check("R1 vset at reset", vset_o, 20);
        check("R1 busy at reset", ramp_busy_o, 0);
    endtask

    task automatic t_pre_soft_start();
        vout_lo_i = 7'd60; strobe(); cyc(2);
        check("R2 jump on strobe", vset_o, 60);
        check("R2 no busy before soft start", ramp_busy_o, 0);
        vsel_i = 1'b1; ticks(10); cyc(2);
        check("R2 R6 jump to high preset", vset_o, 40);
        vsel_i = 1'b0; ticks(10); cyc(2);
        check("R2 R6 jump back to low preset", vset_o, 60);
        ss_done_i = 1'b1; cyc(1);
        cur = 60;
        check("R9 idle after soft start", ramp_busy_o, 0);
    endtask

    task automatic t_ramp(input logic [1:0] slew, input int lim, input int to, input string tag);
        int dir;
        slew_i = slew;
        vout_lo_i = 7'(to); strobe(); cyc(2);
        check({tag, " busy during ramp (R9)"}, ramp_busy_o, 1);
        dir = (to > cur) ? 1 : -1;
        walk((to > cur) ? to - cur : cur - to, lim, dir, tag);
        cyc(1);
        check({tag, " stops at target (R5)"}, vset_o, to);
        check({tag, " busy clear at end (R9)"}, ramp_busy_o, 0);
    endtask

    task automatic t_slew_change();
        slew_i = 2'b00; vout_lo_i = 7'd65; strobe(); cyc(2);
        ticks(30);
        check("R10 no step after 30 of 50", vset_o, 62);
        slew_i = 2'b10; tick1();
        cur = 63;
        check("R10 step on next tick after shorter slew", vset_o, 63);
        walk(2, 10, 1, "R10 new interval");
        cyc(1);
        check("R10 ramp done", ramp_busy_o, 0);
    endtask

    task automatic t_retarget();
        slew_i = 2'b11; vout_lo_i = 7'd70; strobe(); cyc(2);
        walk(2, 5, 1, "R8 up leg");
        vout_lo_i = 7'd66; strobe(); cyc(2);
        check("R8 busy after retarget", ramp_busy_o, 1);
        walk(1, 5, -1, "R8 reversed leg");
        cyc(1);
        check("R8 reached new target", vset_o, 66);
        check("R8 idle at new target", ramp_busy_o, 0);
    endtask

    task automatic t_glitch();
        vout_hi_i = 7'd80; vsel_i = 1'b1; ticks(9);
        vsel_i = 1'b0; cyc(1); ticks(20);
        check("R7 short select pulse ignored vset", vset_o, 66);
        check("R7 short select pulse ignored busy", ramp_busy_o, 0);
    endtask

    task automatic t_no_strobe();
        vout_lo_i = 7'd10; ticks(10); cyc(2);
        check("R11 preset edit without strobe", vset_o, 66);
        check("R11 no ramp without strobe", ramp_busy_o, 0);
        vout_lo_i = 7'd66; vout_hi_i = 7'd20; strobe(); cyc(3);
        check("R11 strobe with unchanged value", vset_o, 66);
        check("R11 strobe with unchanged value busy", ramp_busy_o, 0);
    endtask

    task automatic t_vsel_ramp();
        vout_hi_i = 7'd68; slew_i = 2'b11;
        vsel_i = 1'b1; ticks(9); cyc(2);
        check("R6 not acted on at 9 ticks", ramp_busy_o, 0);
        tick1(); cyc(2);
        check("R6 ramp begins after 10 ticks", ramp_busy_o, 1);
        walk(2, 5, 1, "R6 high preset ramp");
        cyc(1);
        check("R6 reached high preset", vset_o, 68);
        check("R6 idle at high preset", ramp_busy_o, 0);
    endtask

    initial begin
        cyc(1);
        t_reset();
        t_pre_soft_start();
        t_ramp(2'b11, 5, 63, "R4 slew11");
        t_ramp(2'b10, 10, 61, "R4 R5 slew10 down");
        t_ramp(2'b01, 20, 63, "R4 slew01");
        t_ramp(2'b00, 50, 62, "R4 R5 slew00 down");
        t_slew_change();
        t_retarget();
        t_glitch();
        t_no_strobe();
        t_vsel_ramp();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule